// File: doc/BRIEF.md
# Packed Sub-Word RAM

This block is a 256-entry random-access memory with an 8-bit entry address. Its backing store is 128 wide words of 26 bits. Each wide word carries two 13-bit entries side by side, and no bit of the word is left unused. The lowest address bit picks the half of the word. The seven bits above it pick the wide word.

Every access passes through a fixed three-stage pipeline. First the request is registered. Next the whole addressed word is fetched. Finally the chosen half is steered onto the read port. A write is a read-modify-write on the fetched word: the new field goes into its slot, and the other half is written back with its stored value. Write data is 8 bits wide and is zero-extended into the 13-bit field. The top five bits of every entry are therefore always zero in this configuration.

When write and read are requested together, the write happens first and the read returns the new value. A read-disabled request produces zero on the read port. A synchronous active-low reset clears the entire store and the pipeline.

Top module: `packed_subword_ram`

## Requirements
- R1: The store holds 128 words of 26 bits. Address bits [7:1] select the word. Address bit 0 selects the entry within it: 0 means bits [12:0] and 1 means bits [25:13]. Each of the 256 addresses holds its own independent value.
- R2: A write replaces only the addressed 13-bit entry. The other entry in the same word keeps its stored value.
- R3: Storage changes only for a request with `wr_en` = 1. A request with `wr_en` = 0 leaves every entry unchanged, whatever `wr_data` carries.
- R4: A request sampled at rising edge N with `rd_en` = 1 shows the addressed entry on `rd_data` after rising edge N+2. This holds for requests issued on consecutive cycles.
- R5: A request sampled with `rd_en` = 0 drives `rd_data` to zero after the same two-edge latency.
- R6: `wr_data` is zero-extended into the 13-bit entry, so `rd_data[12:8]` is always zero.
- R7: A request with both `wr_en` and `rd_en` set performs the write first, and its read returns the newly written value.
- R8: While `rst_n` is low at a rising edge, all entries and `rd_data` are cleared to zero.
- R9: A read sampled on the edge right after a write to the same address returns the written value. There is no pipeline hazard.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Entry address: [7:1] selects the word, [0] selects the half |
| wr_data | input | 8 | Write data, zero-extended into the entry |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| rd_data | output | 13 | Read result, valid two edges after the request is sampled |

## Verification
The assertions check several things on every cycle: the read port is zero after reset and after read-disabled requests, the upper five bits of the read data stay clear, a combined write-and-read returns the written value, and a read issued right behind a write to the same address sees that write. Only the bench's sweeps can show the rest. They show that every one of the 256 addresses holds an independent value, that overwriting one half of a word leaves the other half intact, and that write-disabled requests carrying data change nothing. They also cover a reset in mid-run clearing the whole store.

// File: rtl/psr_pkg.sv
// Package psr_pkg
// Shared default geometry for the packed sub-word RAM.
// Assumes the entries per word are a power of two and at least two, and
// that the entry is wider than the write data.
package psr_pkg;
    localparam int PSR_ADDR_W  = 8;
    localparam int PSR_DIN_W   = 8;
    localparam int PSR_FIELD_W = 13;
    localparam int PSR_NFIELDS = 2;
endpackage

// File: rtl/psr_req_stage.sv
// Module psr_req_stage
// Registers one access request (address, data, enables) at the block's edge.
// Assumes a synchronous active-low reset. Enables clear to zero on reset.
module psr_req_stage #(
    parameter int ADDR_W = 8,
    parameter int DIN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DIN_W-1:0]  wr_data,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [ADDR_W-1:0] rq_addr,
    output logic [DIN_W-1:0]  rq_data,
    output logic              rq_we,
    output logic              rq_re
);
    // Capture the incoming request once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_addr <= '0;
            rq_data <= '0;
            rq_we   <= 1'b0;
            rq_re   <= 1'b0;
        end else begin
            rq_addr <= addr;
            rq_data <= wr_data;
            rq_we   <= wr_en;
            rq_re   <= rd_en;
        end
    end
endmodule

// File: rtl/psr_word_store.sv
// Module psr_word_store
// Holds the wide words. Each cycle it fetches the indexed word, merges the
// write field into its slot (read-modify-write) and commits the merged word.
// It registers the fetched word for the steering stage. When a write is
// present, the merged word is forwarded so the read sees the new value.
// Assumes the index and selector are already registered by the caller.
module psr_word_store #(
    parameter int DIN_W   = 8,
    parameter int FIELD_W = 13,
    parameter int NFIELDS = 2,
    parameter int IDX_W   = 7,
    parameter int SEL_W   = 1,
    localparam int WORD_W = FIELD_W * NFIELDS,
    localparam int WORDS  = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DIN_W-1:0]  wdata,
    input  logic              we,
    input  logic              re,
    output logic [WORD_W-1:0] fetch_q,
    output logic [SEL_W-1:0]  sel_q,
    output logic              re_q
);
    logic [WORD_W-1:0]  mem [WORDS];
    logic [WORD_W-1:0]  cur_word;
    logic [WORD_W-1:0]  merged;
    logic [FIELD_W-1:0] wfield;

    // Read the addressed word and widen the write data.
    always_comb begin
        cur_word = mem[idx];
        wfield   = {{(FIELD_W-DIN_W){1'b0}}, wdata};
    end

    // Each slot takes the new field when selected, else its stored value.
    for (genvar f = 0; f < NFIELDS; f++) begin : g_merge
        assign merged[f*FIELD_W +: FIELD_W] =
            (we && (sel == SEL_W'(f))) ? wfield : cur_word[f*FIELD_W +: FIELD_W];
    end

    // Commit writes and clear the whole store on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) begin
                mem[w] <= '0;
            end
        end else if (we) begin
            mem[idx] <= merged;
        end
    end

    // Register the fetched (or freshly merged) word for steering.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_q <= '0;
            sel_q   <= '0;
            re_q    <= 1'b0;
        end else begin
            fetch_q <= we ? merged : cur_word;
            sel_q   <= sel;
            re_q    <= re;
        end
    end
endmodule

// File: rtl/psr_field_steer.sv
// Module psr_field_steer
// Picks one entry out of the fetched wide word and registers it as the read
// result. A read-disabled slot yields zero.
// Assumes the word, selector and read flag arrive aligned in the same cycle.
module psr_field_steer #(
    parameter int FIELD_W = 13,
    parameter int NFIELDS = 2,
    parameter int SEL_W   = 1,
    localparam int WORD_W = FIELD_W * NFIELDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_W-1:0]  word,
    input  logic [SEL_W-1:0]   sel,
    input  logic               re,
    output logic [FIELD_W-1:0] rd_data
);
    // Drive the selected entry, or zero, onto the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (re) begin
            rd_data <= word[int'(sel)*FIELD_W +: FIELD_W];
        end else begin
            rd_data <= '0;
        end
    end
endmodule

// File: rtl/packed_subword_ram.sv
// Module packed_subword_ram
// A 2**ADDR_W entry RAM that packs NFIELDS entries of FIELD_W bits into each
// storage word. The low address bits pick the entry, the rest pick the word.
// Latency is fixed: a request sampled at edge N shows on rd_data after N+2.
// Assumes NFIELDS is a power of two (at least 2) and FIELD_W > DIN_W.
module packed_subword_ram
    import psr_pkg::*;
#(
    parameter int ADDR_W  = PSR_ADDR_W,
    parameter int DIN_W   = PSR_DIN_W,
    parameter int FIELD_W = PSR_FIELD_W,
    parameter int NFIELDS = PSR_NFIELDS,
    localparam int SEL_W  = $clog2(NFIELDS),
    localparam int IDX_W  = ADDR_W - SEL_W,
    localparam int WORD_W = FIELD_W * NFIELDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DIN_W-1:0]   wr_data,
    input  logic               wr_en,
    input  logic               rd_en,
    output logic [FIELD_W-1:0] rd_data
);
    logic [ADDR_W-1:0] rq_addr;
    logic [DIN_W-1:0]  rq_data;
    logic              rq_we;
    logic              rq_re;
    logic [WORD_W-1:0] fetch_q;
    logic [SEL_W-1:0]  sel_q;
    logic              re_q;

    psr_req_stage #(.ADDR_W(ADDR_W), .DIN_W(DIN_W)) u_req (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
        .wr_en(wr_en), .rd_en(rd_en), .rq_addr(rq_addr), .rq_data(rq_data),
        .rq_we(rq_we), .rq_re(rq_re)
    );

    psr_word_store #(
        .DIN_W(DIN_W), .FIELD_W(FIELD_W), .NFIELDS(NFIELDS),
        .IDX_W(IDX_W), .SEL_W(SEL_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .idx(rq_addr[ADDR_W-1:SEL_W]), .sel(rq_addr[SEL_W-1:0]),
        .wdata(rq_data), .we(rq_we), .re(rq_re),
        .fetch_q(fetch_q), .sel_q(sel_q), .re_q(re_q)
    );

    psr_field_steer #(.FIELD_W(FIELD_W), .NFIELDS(NFIELDS), .SEL_W(SEL_W)) u_steer (
        .clk(clk), .rst_n(rst_n), .word(fetch_q), .sel(sel_q), .re(re_q),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/psr_checker.sv
// Module psr_checker
// Port-level properties of packed_subword_ram, attached by bind.
// A request sampled at edge P is visible in rd_data as sampled at edge P+3.
// A saturating counter of edges since reset keeps every $past in range.
module psr_checker #(
    parameter int ADDR_W  = 8,
    parameter int DIN_W   = 8,
    parameter int FIELD_W = 13
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  addr,
    input logic [DIN_W-1:0]   wr_data,
    input logic               wr_en,
    input logic               rd_en,
    input logic [FIELD_W-1:0] rd_data
);
    logic [2:0] since_rst;

    // Count edges since reset release, saturating at 7.
    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    // R8: the first cycle out of reset shows zero on the read port.
    assert_reset_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'd0) |-> (rd_data == '0));

    // R5: a read-disabled request yields zero after the latency.
    assert_idle_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd3 && !$past(rd_en, 3)) |-> (rd_data == '0));

    // R6: the bits above the write-data width never carry a one.
    assert_upper_bits_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[FIELD_W-1:DIN_W] == '0);

    // R7: a combined write and read returns the written value.
    assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd3 && $past(wr_en, 3) && $past(rd_en, 3))
        |-> (rd_data == {{(FIELD_W-DIN_W){1'b0}}, $past(wr_data, 3)}));

    // R9: a read right behind a write to the same address sees it.
    assert_no_hazard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4 && $past(wr_en, 4) && $past(rd_en, 3) && !$past(wr_en, 3)
         && ($past(addr, 4) == $past(addr, 3)))
        |-> (rd_data == {{(FIELD_W-DIN_W){1'b0}}, $past(wr_data, 4)}));
endmodule

bind packed_subword_ram psr_checker #(
    .ADDR_W(ADDR_W), .DIN_W(DIN_W), .FIELD_W(FIELD_W)
) u_psr_checker (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
    .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data)
);

// File: tb/test_packed_subword_ram.sv
// Bench for packed_subword_ram. Inputs are driven at the falling edge.
// A request driven at one falling edge is checked at the third falling edge
// after it, once its two-edge latency has passed.
module test_packed_subword_ram;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [12:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] model [256];
    bit         pv [3];
    logic [7:0] pe [3];
    int         pa [3];
    string      pt [3];

    always #2 clk = ~clk;

    packed_subword_ram i_packed_subword_ram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
        .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data)
    );

    function automatic logic [7:0] pat(input int a, input int k);
        return 8'((a * 37 + 11 + k * 91) & 255);
    endfunction

    task automatic check(input string tag, input logic [12:0] got, input logic [12:0] exp, input int a);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, got, exp);
        end
    endtask

    // One request per cycle; checks the request issued three steps earlier.
    task automatic step(input bit we, input bit re, input int a, input logic [7:0] d, input string tag);
        @(negedge clk);
        if (pv[2]) check(pt[2], rd_data, {5'b0, pe[2]}, pa[2]);
        for (int i = 2; i > 0; i--) begin
            pv[i] = pv[i-1]; pe[i] = pe[i-1]; pa[i] = pa[i-1]; pt[i] = pt[i-1];
        end
        if (we) model[a] = d;
        pv[0] = 1'b1;
        pe[0] = re ? model[a] : 8'h00;
        pa[0] = a;
        pt[0] = tag;
        addr = 8'(a); wr_data = d; wr_en = we; rd_en = re;
    endtask

    task automatic flush();
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 0, 8'h00, "R5");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0;
        for (int i = 0; i < 3; i++) pv[i] = 1'b0;
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        check("R8", rd_data, 13'h0, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R8: every entry reads zero after reset (R4 pipelined reads).
        for (int a = 0; a < 256; a++) step(1'b0, 1'b1, a, 8'h00, "R8");
        flush();
        // R1: fill all addresses with distinct values, read them back.
        for (int a = 0; a < 256; a++) step(1'b1, 1'b0, a, pat(a, 0), "R1");
        for (int a = 0; a < 256; a++) step(1'b0, 1'b1, a, 8'h00, "R1");
        flush();
        // R2: rewrite only the low halves, both halves must read correctly.
        for (int a = 0; a < 256; a += 2) step(1'b1, 1'b0, a, ~pat(a, 0), "R2");
        for (int a = 0; a < 256; a++) step(1'b0, 1'b1, a, 8'h00, "R2");
        // R2: rewrite only the high halves.
        for (int a = 1; a < 256; a += 2) step(1'b1, 1'b0, a, pat(a, 2), "R2");
        for (int a = 0; a < 256; a++) step(1'b0, 1'b1, a, 8'h00, "R2");
        // R3: write-disabled requests carry data but must change nothing (R5 slots).
        for (int a = 0; a < 256; a++) step(1'b0, 1'b0, a, 8'hA5, "R5");
        for (int a = 0; a < 256; a++) step(1'b0, 1'b1, a, 8'h00, "R3");
        // R6: all-ones data stays within the low 8 bits.
        for (int a = 0; a < 16; a++) step(1'b1, 1'b0, a, 8'hFF, "R6");
        for (int a = 0; a < 16; a++) step(1'b0, 1'b1, a, 8'h00, "R6");
        // R7: combined write and read returns the new value.
        for (int a = 0; a < 256; a += 5) step(1'b1, 1'b1, a, pat(a, 3), "R7");
        // R9: a read right behind a write, same address and neighbour half.
        for (int a = 0; a < 256; a += 3) begin
            step(1'b1, 1'b0, a, pat(a, 4), "R9");
            step(1'b0, 1'b1, a, 8'h00, "R9");
            step(1'b0, 1'b1, a ^ 1, 8'h00, "R9");
        end
        // R4: alternating back-to-back reads and writes across words.
        for (int a = 0; a < 128; a++) begin
            step(1'b1, 1'b0, 255 - a, pat(a, 5), "R4");
            step(1'b0, 1'b1, a, 8'h00, "R4");
        end
        flush();
        // R8: a reset in mid-run clears the whole store.
        do_reset();
        for (int a = 0; a < 256; a++) step(1'b0, 1'b1, a, 8'h00, "R8");
        flush();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule